// File: doc/BRIEF.md
# Strobed Backplane Bus Cycle Master

This block runs single bus cycles on a shared backplane on behalf of local logic. The backplane carries a 16-bit address, a 16-bit data path and active-low control lines. A request gives an address, write data, a direction flag and a space flag that selects memory or peripheral space. The controller then sequences one complete cycle. It drives the address and the direction line, waits a programmable set-up interval, and asserts the strobe for the selected space. On writes it drops a separate data-valid strobe after a short delay. It keeps the cycle open while a slave holds the wait line low, releases the strobe, and holds address, direction and write data for a hold interval before it frees the bus.

All nanosecond limits are expressed as clock counts through parameters. The wait line from the slave passes through a two-stage synchroniser before the sequencer uses it. A timeout closes a cycle whose wait never clears and reports it with the done pulse. A narrow mode, chosen per request, restricts the transfer to the low byte lane. In narrow mode the upper lane is never enabled and is returned as zero. Data-bus ownership is shown by one output-enable bit per byte lane.

Top module: `bus_cycle_master`

## Requirements
- R1: During and after reset, both space strobes, the direction line and the write-data strobe are high (inactive), all lane enables are 0, and busy and done are 0.
- R2: An accepted request drives its address and the direction line (low for a write) for exactly SETUP_CLKS cycles before a strobe falls. Both stay unchanged while the strobe is low.
- R3: req_periph = 0 selects the memory strobe and req_periph = 1 selects the peripheral strobe. The two strobes are never low together.
- R4: The strobe stays low for at least MIN_STROBE_CLKS cycles. It is released at the end of the first cycle, at or past that minimum, in which the synchronised wait line (two clocks of latency) is inactive. A slave that pulls the wait line low from the first strobe cycle for W > 0 cycles gives a strobe length of max(MIN_STROBE_CLKS, W+3).
- R5: On a write, write data is driven from the first set-up cycle. The write-data strobe falls SYN_CLKS cycles after the strobe falls and rises together with it. It never falls on a read.
- R6: After the strobe rises, the address, the direction line and the write-data enables are held for exactly HOLD_CLKS cycles. The bus is then released, with the direction line high and the enables at 0.
- R7: On a read, the data input is captured on the clock edge that releases the strobe. rsp_done is a single-cycle pulse in the first cycle after the strobe rises, and rsp_rdata is valid in that cycle.
- R8: If the synchronised wait line is still active in strobe cycle TIMEOUT_CLKS, the strobe is released after exactly TIMEOUT_CLKS cycles and rsp_timeout is high together with rsp_done. With W+3 equal to TIMEOUT_CLKS the cycle ends normally and rsp_timeout stays low.
- R9: With req_narrow = 1, only lane 0 (data bits 7:0) is driven, so the enables read 2'b01 on a write. A read returns bits 15:8 as zero. With req_narrow = 0, a write drives both lanes (2'b11).
- R10: A request is taken only when req_valid is high and busy is low. req_valid raised while busy has no effect: the running cycle keeps its address, and no further cycle starts once that request is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 16 | Cycle address |
| req_wdata | input | 16 | Write data |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_periph | input | 1 | 1 = peripheral space, 0 = memory space |
| req_narrow | input | 1 | 1 = low byte lane only |
| busy | output | 1 | A cycle is in progress; requests are not taken |
| bus_addr | output | 16 | Address lines |
| bus_write_n | output | 1 | Direction line, low = write |
| bus_mem_stb_n | output | 1 | Memory-space strobe, active low |
| bus_per_stb_n | output | 1 | Peripheral-space strobe, active low |
| bus_syn_n | output | 1 | Write-data-valid strobe, active low |
| bus_wait_n | input | 1 | Slave wait line, active low, asynchronous |
| bus_data_out | output | 16 | Write data to the bus |
| bus_data_oe | output | 2 | Per-lane data drive enable (bit 0 = bits 7:0) |
| bus_data_in | input | 16 | Data from the bus |
| rsp_rdata | output | 16 | Captured read data |
| rsp_done | output | 1 | One-cycle cycle-complete pulse |
| rsp_timeout | output | 1 | Wait timeout, valid with rsp_done |

## Verification
The embedded properties assume that req_narrow, req_write and req_periph matter only on the accepting edge. They also assume the slave wait line is the only asynchronous input and is used only after synchronisation. The bench keeps request fields steady from the request edge onwards. It changes the narrow mode only between cycles. Its slave model pulls the wait line low from the first strobe cycle, for a chosen number of cycles, and only while a strobe is low. This keeps the strobe length a closed-form function of that count.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_STROBE,
        PH_HOLD
    } phase_e;

    typedef enum logic {
        SPACE_MEM,
        SPACE_PER
    } space_e;

    typedef struct packed {
        logic   write;
        space_e space;
        logic   narrow;
    } cmd_t;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic int unsigned count_width(int unsigned top);
        return $clog2(top + 1) + 1;
    endfunction

endpackage

// File: rtl/bcm_sync2.sv
module bcm_sync2 #(
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= RESET_VAL;
            q      <= RESET_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/bcm_seq.sv
module bcm_seq
    import bcm_pkg::*;
#(
    parameter int unsigned SETUP_CLKS      = 3,
    parameter int unsigned SYN_CLKS        = 1,
    parameter int unsigned MIN_STROBE_CLKS = 4,
    parameter int unsigned HOLD_CLKS       = 2,
    parameter int unsigned TIMEOUT_CLKS    = 24
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   start,
    input  logic   is_write,
    input  logic   wait_req,
    output phase_e phase,
    output logic   strobe_on,
    output logic   syn_on,
    output logic   capture,
    output logic   done,
    output logic   timeout
);
    localparam int unsigned CNT_W =
        count_width(max4(SETUP_CLKS, MIN_STROBE_CLKS, HOLD_CLKS, TIMEOUT_CLKS));
    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t LAST_SETUP   = cnt_t'(SETUP_CLKS - 1);
    localparam cnt_t LAST_MIN     = cnt_t'(MIN_STROBE_CLKS - 1);
    localparam cnt_t LAST_HOLD    = cnt_t'(HOLD_CLKS - 1);
    localparam cnt_t LAST_TIMEOUT = cnt_t'(TIMEOUT_CLKS - 1);
    localparam cnt_t SYN_AT       = cnt_t'(SYN_CLKS);

    cnt_t cnt;
    logic release_ok;
    logic expire;

    assign strobe_on  = (phase == PH_STROBE);
    assign release_ok = (cnt >= LAST_MIN) && !wait_req;
    assign expire     = (cnt == LAST_TIMEOUT);
    assign capture    = strobe_on && (release_ok || expire);
    assign syn_on     = strobe_on && is_write && (cnt >= SYN_AT);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            done    <= 1'b0;
            timeout <= 1'b0;
        end else begin
            done    <= capture;
            timeout <= capture && !release_ok;
            unique case (phase)
                PH_IDLE: begin
                    cnt <= '0;
                    if (start) phase <= PH_SETUP;
                end
                PH_SETUP: begin
                    if (cnt == LAST_SETUP) begin
                        phase <= PH_STROBE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_STROBE: begin
                    if (capture) begin
                        phase <= PH_HOLD;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt == LAST_HOLD) begin
                        phase <= PH_IDLE;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    // R7: completion is a single-cycle pulse
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: timeout is only reported together with completion
    p_timeout_with_done_r8: assert property (@(posedge clk) disable iff (rst)
        timeout |-> done);

    // R4: the strobe never ends before its minimum length
    p_min_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_on) |-> ($past(cnt) >= LAST_MIN));

    // R5: the write-data strobe only inside a write strobe
    p_syn_in_write_r5: assert property (@(posedge clk) disable iff (rst)
        syn_on |-> (strobe_on && is_write));

    // R6: hold phase follows the strobe
    p_hold_after_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(strobe_on) |-> (phase == PH_HOLD));
endmodule

// File: rtl/bcm_datapath.sv
module bcm_datapath
    import bcm_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   load,
    input  cmd_t                   cmd_in,
    input  logic [ADDR_W-1:0]      addr_in,
    input  logic [DATA_W-1:0]      wdata_in,
    input  logic                   capture,
    input  logic                   own_bus,
    input  logic [DATA_W-1:0]      bus_data_in,
    output cmd_t                   cmd_q,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic [DATA_W-1:0]      data_out,
    output logic [DATA_W/8-1:0]    data_oe,
    output logic [DATA_W-1:0]      rdata
);
    localparam int unsigned LANES = DATA_W / 8;

    logic [DATA_W-1:0] wdata_q;
    logic [LANES-1:0]  lane_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q    <= '0;
            bus_addr <= '0;
            wdata_q  <= '0;
        end else if (load) begin
            cmd_q    <= cmd_in;
            bus_addr <= addr_in;
            wdata_q  <= wdata_in;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (g == 0) begin : g_low
            assign lane_en[g] = 1'b1;
        end else begin : g_high
            assign lane_en[g] = !cmd_q.narrow;
        end

        assign data_out[g*8 +: 8] = lane_en[g] ? wdata_q[g*8 +: 8] : 8'h00;
        assign data_oe[g]         = own_bus && cmd_q.write && lane_en[g];

        always_ff @(posedge clk) begin
            if (rst) begin
                rdata[g*8 +: 8] <= 8'h00;
            end else if (capture && !cmd_q.write) begin
                rdata[g*8 +: 8] <= lane_en[g] ? bus_data_in[g*8 +: 8] : 8'h00;
            end
        end
    end

    if (LANES > 1) begin : g_narrow_chk
        // R9: upper lane never driven in narrow mode
        p_narrow_upper_off_r9: assert property (@(posedge clk) disable iff (rst)
            cmd_q.narrow |-> !data_oe[LANES-1]);
    end
endmodule

// File: rtl/bus_cycle_master.sv
module bus_cycle_master
    import bcm_pkg::*;
#(
    parameter int unsigned ADDR_W          = 16,
    parameter int unsigned DATA_W          = 16,
    parameter int unsigned SETUP_CLKS      = 3,
    parameter int unsigned SYN_CLKS        = 1,
    parameter int unsigned MIN_STROBE_CLKS = 4,
    parameter int unsigned HOLD_CLKS       = 2,
    parameter int unsigned TIMEOUT_CLKS    = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic                req_write,
    input  logic                req_periph,
    input  logic                req_narrow,
    output logic                busy,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic                bus_write_n,
    output logic                bus_mem_stb_n,
    output logic                bus_per_stb_n,
    output logic                bus_syn_n,
    input  logic                bus_wait_n,
    output logic [DATA_W-1:0]   bus_data_out,
    output logic [DATA_W/8-1:0] bus_data_oe,
    input  logic [DATA_W-1:0]   bus_data_in,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                rsp_done,
    output logic                rsp_timeout
);
    phase_e phase;
    cmd_t   cmd_in;
    cmd_t   cmd_q;
    logic   start;
    logic   wait_sync_n;
    logic   strobe_on;
    logic   syn_on;
    logic   capture;
    logic   any_stb_n;

    assign cmd_in = '{write:  req_write,
                      space:  req_periph ? SPACE_PER : SPACE_MEM,
                      narrow: req_narrow};

    assign busy  = (phase != PH_IDLE);
    assign start = req_valid && !busy;

    bcm_sync2 #(.RESET_VAL(1'b1)) i_wait_sync (
        .clk (clk),
        .rst (rst),
        .d   (bus_wait_n),
        .q   (wait_sync_n)
    );

    bcm_seq #(
        .SETUP_CLKS      (SETUP_CLKS),
        .SYN_CLKS        (SYN_CLKS),
        .MIN_STROBE_CLKS (MIN_STROBE_CLKS),
        .HOLD_CLKS       (HOLD_CLKS),
        .TIMEOUT_CLKS    (TIMEOUT_CLKS)
    ) i_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .is_write  (cmd_q.write),
        .wait_req  (!wait_sync_n),
        .phase     (phase),
        .strobe_on (strobe_on),
        .syn_on    (syn_on),
        .capture   (capture),
        .done      (rsp_done),
        .timeout   (rsp_timeout)
    );

    bcm_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_datapath (
        .clk         (clk),
        .rst         (rst),
        .load        (start),
        .cmd_in      (cmd_in),
        .addr_in     (req_addr),
        .wdata_in    (req_wdata),
        .capture     (capture),
        .own_bus     (busy),
        .bus_data_in (bus_data_in),
        .cmd_q       (cmd_q),
        .bus_addr    (bus_addr),
        .data_out    (bus_data_out),
        .data_oe     (bus_data_oe),
        .rdata       (rsp_rdata)
    );

    assign bus_mem_stb_n = !(strobe_on && (cmd_q.space == SPACE_MEM));
    assign bus_per_stb_n = !(strobe_on && (cmd_q.space == SPACE_PER));
    assign bus_write_n   = !(busy && cmd_q.write);
    assign bus_syn_n     = !syn_on;
    assign any_stb_n     = bus_mem_stb_n && bus_per_stb_n;

    // R3: only one space strobe at a time
    p_one_space_r3: assert property (@(posedge clk) disable iff (rst)
        !(!bus_mem_stb_n && !bus_per_stb_n));

    // R2: address and direction steady while a strobe stays low
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!any_stb_n && !$past(any_stb_n)) |-> ($stable(bus_addr) && $stable(bus_write_n)));

    // R2: a strobe only falls after the cycle has been set up
    p_setup_before_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(any_stb_n) |-> ($past(busy) && $stable(bus_addr) && $stable(bus_write_n)));

    // R6: address and direction held across the strobe release
    p_hold_on_rise_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(any_stb_n) |-> ($stable(bus_addr) && $stable(bus_write_n) && busy));

    // R5: write data is driven whenever the write-data strobe is low
    p_data_under_syn_r5: assert property (@(posedge clk) disable iff (rst)
        !bus_syn_n |-> (bus_data_oe[0] && !bus_write_n));

    // R10: no new request loads while a cycle is running
    p_no_reload_r10: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy && !$rose(busy)) |-> $stable(bus_addr));
endmodule

// File: tb/test_bus_cycle_master.sv
module test_bus_cycle_master;
    localparam int SETUP = 3;
    localparam int SYNC  = 1;
    localparam int MINS  = 4;
    localparam int HOLD  = 2;
    localparam int TOUT  = 24;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_write = 1'b0;
    logic        req_periph = 1'b0;
    logic        req_narrow = 1'b0;
    logic        busy;
    logic [15:0] bus_addr;
    logic        bus_write_n, bus_mem_stb_n, bus_per_stb_n, bus_syn_n;
    logic        bus_wait_n = 1'b1;
    logic [15:0] bus_data_out;
    logic [1:0]  bus_data_oe;
    logic [15:0] bus_data_in = '0;
    logic [15:0] rsp_rdata;
    logic        rsp_done, rsp_timeout;

    bus_cycle_master #(
        .SETUP_CLKS(SETUP), .SYN_CLKS(SYNC), .MIN_STROBE_CLKS(MINS),
        .HOLD_CLKS(HOLD), .TIMEOUT_CLKS(TOUT)
    ) i_bus_cycle_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_periph(req_periph),
        .req_narrow(req_narrow), .busy(busy), .bus_addr(bus_addr),
        .bus_write_n(bus_write_n), .bus_mem_stb_n(bus_mem_stb_n),
        .bus_per_stb_n(bus_per_stb_n), .bus_syn_n(bus_syn_n),
        .bus_wait_n(bus_wait_n), .bus_data_out(bus_data_out),
        .bus_data_oe(bus_data_oe), .bus_data_in(bus_data_in),
        .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // expectations of the running cycle
    logic [15:0] exp_addr, exp_wdata, rd_pat;
    logic        exp_wr, exp_per, exp_narrow;
    int          wait_cfg = 0;

    // monitor results
    int          pre_cnt, strobe_len, syn_idx, hold_cnt, done_cnt, done_pos, slv_k;
    logic        addr_bad, hold_bad, both_bad, syn_bad, mem_seen, per_seen, err_cap;
    logic [15:0] syn_data, rdata_cap;
    logic [1:0]  syn_oe;
    logic        prev_busy = 1'b0;

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_oe_f(input logic wr, input logic nar);
        if (!wr) return 2'b00;
        return nar ? 2'b01 : 2'b11;
    endfunction

    function automatic int exp_len_f(input int w);
        if (w == 0) return MINS;
        if (w + 3 > TOUT) return TOUT;
        return (w + 3 > MINS) ? w + 3 : MINS;
    endfunction

    always @(negedge clk) begin
        logic stb_low;
        stb_low = !bus_mem_stb_n || !bus_per_stb_n;
        if (busy && !prev_busy) begin
            pre_cnt = 0; strobe_len = 0; syn_idx = -1; hold_cnt = 0;
            done_cnt = 0; done_pos = 0; addr_bad = 0; hold_bad = 0;
            both_bad = 0; syn_bad = 0; mem_seen = 0; per_seen = 0; err_cap = 0;
            syn_data = '0; syn_oe = '0; rdata_cap = '0;
        end
        if (busy) begin
            if (!bus_mem_stb_n && !bus_per_stb_n) both_bad = 1;
            if (!bus_mem_stb_n) mem_seen = 1;
            if (!bus_per_stb_n) per_seen = 1;
            if (!bus_syn_n && !exp_wr) syn_bad = 1;
            if (stb_low) begin
                strobe_len++;
                if (bus_addr != exp_addr || bus_write_n != !exp_wr) addr_bad = 1;
                if (!bus_syn_n && syn_idx < 0) begin
                    syn_idx  = strobe_len - 1;
                    syn_data = bus_data_out;
                    syn_oe   = bus_data_oe;
                end
            end else if (strobe_len == 0) begin
                pre_cnt++;
                if (bus_addr != exp_addr || bus_write_n != !exp_wr ||
                    bus_data_oe != exp_oe_f(exp_wr, exp_narrow)) addr_bad = 1;
            end else begin
                hold_cnt++;
                if (bus_addr != exp_addr || bus_write_n != !exp_wr ||
                    bus_data_oe != exp_oe_f(exp_wr, exp_narrow) || !bus_syn_n) hold_bad = 1;
            end
            if (rsp_done) begin
                done_cnt++;
                done_pos  = hold_cnt;
                rdata_cap = rsp_rdata;
                err_cap   = rsp_timeout;
            end
        end
        prev_busy = busy;
        // slave model
        if (stb_low) begin
            bus_wait_n  = (slv_k < wait_cfg) ? 1'b0 : 1'b1;
            bus_data_in = exp_wr ? 16'h0000 : rd_pat;
            slv_k++;
        end else begin
            slv_k       = 0;
            bus_wait_n  = 1'b1;
            bus_data_in = 16'h0000;
        end
    end

    task automatic run(input logic [15:0] a, input logic [15:0] d, input logic wr,
                       input logic per, input logic nar, input int w, input logic noise);
        int el;
        @(negedge clk);
        exp_addr = a; exp_wdata = d; exp_wr = wr; exp_per = per; exp_narrow = nar;
        wait_cfg = w; rd_pat = 16'($urandom);
        req_addr = a; req_wdata = d; req_write = wr; req_periph = per; req_narrow = nar;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (noise) begin
            req_valid = 1'b1;
            req_addr  = ~a;
        end
        do begin
            @(negedge clk);
            if (!bus_mem_stb_n || !bus_per_stb_n) req_valid = 1'b0;
        end while (busy);
        req_valid = 1'b0;
        el = exp_len_f(w);
        chk(pre_cnt == SETUP, "R2 setup cycles", pre_cnt, SETUP);
        chk(!addr_bad, "R2 address/direction steady", addr_bad, 0);
        chk(!both_bad && mem_seen == !per && per_seen == per, "R3 space strobe",
            {per_seen, mem_seen}, per ? 2 : 1);
        chk(strobe_len == el, "R4 strobe length", strobe_len, el);
        if (wr) begin
            chk(syn_idx == SYNC, "R5 write strobe delay", syn_idx, SYNC);
            chk(syn_data[7:0] == d[7:0] && (nar || syn_data[15:8] == d[15:8]),
                "R5 write data", syn_data, d);
            chk(syn_oe == exp_oe_f(1'b1, nar), "R9 write lane enables", syn_oe,
                exp_oe_f(1'b1, nar));
        end else begin
            chk(!syn_bad && syn_idx < 0, "R5 no write strobe on read", syn_idx, -1);
            chk(rdata_cap == (nar ? {8'h00, rd_pat[7:0]} : rd_pat), "R7 R9 read data",
                rdata_cap, nar ? {8'h00, rd_pat[7:0]} : rd_pat);
        end
        chk(hold_cnt == HOLD && !hold_bad, "R6 hold", hold_cnt, HOLD);
        chk(bus_write_n && bus_data_oe == 2'b00, "R6 release", bus_data_oe, 0);
        chk(done_cnt == 1 && done_pos == 1, "R7 done pulse", done_cnt * 16 + done_pos, 17);
        chk(err_cap == (w + 3 > TOUT), "R8 timeout flag", err_cap, w + 3 > TOUT);
        if (noise) begin
            repeat (3) @(negedge clk);
            chk(!busy && bus_mem_stb_n && bus_per_stb_n, "R10 ignored request", busy, 0);
        end
    endtask

    initial begin
        int cyc;
        cyc = 0;
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(bus_mem_stb_n && bus_per_stb_n && bus_write_n && bus_syn_n &&
            bus_data_oe == 2'b00 && !busy && !rsp_done, "R1 reset state", busy, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(bus_mem_stb_n && bus_per_stb_n && bus_write_n && bus_syn_n &&
            bus_data_oe == 2'b00 && !busy && !rsp_done, "R1 idle after reset", busy, 0);

        // directed corners
        run(16'h1234, 16'hABCD, 1'b1, 1'b0, 1'b0, 0, 1'b0);
        run(16'h4321, 16'h0000, 1'b0, 1'b0, 1'b0, 0, 1'b0);
        run(16'h00F0, 16'h5A5A, 1'b1, 1'b1, 1'b0, 1, 1'b0);
        run(16'hFFFF, 16'h0000, 1'b0, 1'b1, 1'b0, 7, 1'b0);
        run(16'h8001, 16'hC3C3, 1'b1, 1'b0, 1'b1, 2, 1'b0);
        run(16'h7FFE, 16'h0000, 1'b0, 1'b0, 1'b1, 3, 1'b0);
        run(16'h2222, 16'h1111, 1'b1, 1'b0, 1'b0, TOUT - 3, 1'b0);
        run(16'h3333, 16'h0000, 1'b0, 1'b1, 1'b0, TOUT - 2, 1'b0);
        run(16'h4444, 16'h9999, 1'b1, 1'b0, 1'b0, TOUT + 5, 1'b0);
        run(16'h5555, 16'h0000, 1'b0, 1'b0, 1'b0, 2, 1'b1);
        run(16'h6666, 16'h7777, 1'b1, 1'b1, 1'b1, 0, 1'b1);

        // constrained random
        for (int i = 0; i < 40; i++) begin
            run(16'($urandom), 16'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), int'($urandom_range(0, 9)), 1'($urandom_range(0, 3) == 0));
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule